// File: doc/BRIEF.md
# Dual-Target Parallel Bus Access Controller

This block sits behind an asynchronous byte-wide parallel bus with four active-low control pins: a memory select, a register select, a write enable and an output enable, plus a 20-bit address and 8-bit write data. It samples every bus pin through a synchronizer on a fast system clock. It then decodes each combination into one fixed bus mode and steers the access either to a 1M x 8 memory array or to a small clock register file.

Reads are combinational at the targets. The controller presents the address, selects the returning byte and raises the data-pin drive enable. Writes are framed as a window. The window opens when the later of the two relevant enables falls and closes when the earlier one rises. The closing edge produces a single-cycle write strobe carrying the address captured at the opening and the data seen at the closing. A power-fail input vetoes every strobe. A programmable recovery count must pass with write enable high before a new write window can open.

The write side is a four-state machine. IDLE opens a window on a memory-write mode (to MEM_WIN) or on a register-write mode (to REG_WIN). A window either closes or aborts, and both paths go to RECOVER. RECOVER returns to IDLE once write enable has been high for the programmed count.

Top module: `pbus_steer`

## Requirements
- R1: `cyc_mode` reports the decoded bus mode a few cycles after the pins settle. The codes are 0 standby (memory select high, register select high), 1 memory read, 2 memory write, 3 register read, 4 register write and 5 invalid (both selects low). Reset forces code 0, with `bus_oe`, `bus_rdata`, `bad_combo` and both strobes low.
- R2: `bus_oe` is high only in memory read or register read with output enable low. `bus_rdata` then carries `mem_rdata` or `reg_rdata` respectively. While `bus_oe` is low, `bus_rdata` is zero.
- R3: When write enable falls, the drive turns off even though memory select and output enable stay low.
- R4: Both selects low raises `bad_combo`, keeps the drive off and writes to neither target, whatever write enable does.
- R5: Standby never drives the bus and never strobes, even with write enable and output enable low.
- R6: A memory write gives exactly one one-cycle `mem_we` after the window closes. The strobe carries the address captured at the opening on `mem_addr` and the data present at the closing on `mem_wdata`. This holds whichever enable falls last and whichever rises first. `mem_we` and `reg_we` are never high together.
- R7: A register write gives exactly one one-cycle `reg_we`, with `reg_addr` equal to the low 4 address bits and `reg_wdata` equal to the data present at the closing.
- R8: If `pwr_fail` is high at any sampled point of a window, that window produces no strobe.
- R9: If the address changes while a window is open, the window is aborted without a strobe.
- R10: After a window ends, `recov_cycles` consecutive sampled cycles with write enable high must pass before a new window opens. A write cycle that begins earlier produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mem_cs_n | input | 1 | Memory select, active low |
| reg_cs_n | input | 1 | Register select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| bus_addr | input | 20 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| pwr_fail | input | 1 | Supply out of tolerance, blocks writes |
| recov_cycles | input | 8 | Minimum recovery count after a write |
| mem_rdata | input | 8 | Read byte from the memory array |
| reg_rdata | input | 8 | Read byte from the register file |
| mem_addr | output | 20 | Address to the memory array |
| mem_wdata | output | 8 | Write data to the memory array |
| mem_we | output | 1 | One-cycle memory write strobe |
| reg_addr | output | 4 | Address to the register file |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| bus_rdata | output | 8 | Read data toward the data pins |
| bus_oe | output | 1 | Data pin drive enable |
| cyc_mode | output | 3 | Decoded bus mode code |
| bad_combo | output | 1 | Invalid select combination flag |

## Verification
Some properties are checked on every cycle. The two strobes are exclusive and last one cycle each. No strobe follows a cycle in which the synchronized power-fail was high. The drive is only on in a read mode, a quiet bus reads zero, and an invalid combination never drives. Other behaviour only the scenarios can show: which enable frames the window, that the captured address and closing data reach the target, that an address change or a mid-window power dip removes the strobe, and that a write started inside the recovery span is lost.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_MEM_RD  = 3'd1,
        MD_MEM_WR  = 3'd2,
        MD_REG_RD  = 3'd3,
        MD_REG_WR  = 3'd4,
        MD_INVALID = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM_WIN,
        ST_REG_WIN,
        ST_RECOVER
    } wst_e;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{INIT}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
    import pbus_pkg::*;
(
    input  logic  mem_cs_n,
    input  logic  reg_cs_n,
    input  logic  we_n,
    output mode_e mode
);
    always_comb begin
        if (!reg_cs_n && !mem_cs_n) begin
            mode = MD_INVALID;
        end else if (!reg_cs_n) begin
            mode = we_n ? MD_REG_RD : MD_REG_WR;
        end else if (mem_cs_n) begin
            mode = MD_STANDBY;
        end else begin
            mode = we_n ? MD_MEM_RD : MD_MEM_WR;
        end
    end
endmodule

// File: rtl/pbus_wrfsm.sv
module pbus_wrfsm
    import pbus_pkg::*;
#(
    parameter int AW  = 20,
    parameter int DW  = 8,
    parameter int RCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  mode_e          mode,
    input  logic           s_mem_cs_n,
    input  logic           s_reg_cs_n,
    input  logic           s_we_n,
    input  logic           s_pf,
    input  logic [AW-1:0]  s_addr,
    input  logic [DW-1:0]  s_data,
    input  logic [RCW-1:0] recov_cycles,
    output logic           mem_we,
    output logic           reg_we,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data
);
    localparam logic [RCW-1:0] CNT_MAX = '1;

    wst_e           state, nxt;
    logic [AW-1:0]  lat_addr;
    logic           blocked;
    logic [RCW-1:0] cnt;
    logic           mem_abort, mem_close, reg_abort, reg_close, rec_done;
    logic           mem_stb_d, reg_stb_d;

    assign mem_abort = !s_reg_cs_n || (s_addr != lat_addr);
    assign mem_close = s_mem_cs_n || s_we_n;
    assign reg_abort = !s_mem_cs_n || (s_addr != lat_addr);
    assign reg_close = s_reg_cs_n || s_we_n;
    assign rec_done  = s_we_n && (cnt >= recov_cycles);

    // next state and strobe decisions
    always_comb begin
        nxt       = state;
        mem_stb_d = 1'b0;
        reg_stb_d = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (mode == MD_MEM_WR)      nxt = ST_MEM_WIN;
                else if (mode == MD_REG_WR) nxt = ST_REG_WIN;
            end
            ST_MEM_WIN: begin
                if (mem_abort || mem_close) nxt = ST_RECOVER;
                mem_stb_d = !mem_abort && mem_close && !blocked && !s_pf;
            end
            ST_REG_WIN: begin
                if (reg_abort || reg_close) nxt = ST_RECOVER;
                reg_stb_d = !reg_abort && reg_close && !blocked && !s_pf;
            end
            ST_RECOVER: begin
                if (rec_done) nxt = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            reg_we   <= 1'b0;
            wr_data  <= '0;
            lat_addr <= '0;
            blocked  <= 1'b0;
            cnt      <= '0;
        end else begin
            mem_we <= mem_stb_d;
            reg_we <= reg_stb_d;
            if (mem_stb_d || reg_stb_d) wr_data <= s_data;
            if (state == ST_IDLE) begin
                lat_addr <= s_addr;
                blocked  <= s_pf;
            end else begin
                blocked  <= blocked | s_pf;
            end
            if (state != ST_RECOVER || !s_we_n) cnt <= '0;
            else if (cnt != CNT_MAX)            cnt <= cnt + 1'b1;
        end
    end

    assign wr_addr = lat_addr;
endmodule

// File: rtl/pbus_steer.sv
module pbus_steer
    import pbus_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 8,
    parameter int REG_AW = 4,
    parameter int RCW    = 8,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_cs_n,
    input  logic              reg_cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              pwr_fail,
    input  logic [RCW-1:0]    recov_cycles,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     reg_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DW-1:0]     reg_wdata,
    output logic              reg_we,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_oe,
    output logic [2:0]        cyc_mode,
    output logic              bad_combo
);
    localparam int CW = 5;
    localparam int BW = AW + DW;

    logic [CW-1:0] ctl_s;
    logic [BW-1:0] bus_s;
    logic          s_mem_cs_n, s_reg_cs_n, s_we_n, s_oe_n, pf_s;
    logic [AW-1:0] s_addr, wr_addr;
    logic [DW-1:0] s_data, wr_data, rd_sel;
    mode_e         mode;
    logic          oe_d;

    pbus_sync #(.W(CW), .STAGES(SYNC), .INIT(5'b01111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pwr_fail, oe_n, we_n, reg_cs_n, mem_cs_n}),
        .q(ctl_s)
    );

    pbus_sync #(.W(BW), .STAGES(SYNC), .INIT('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_addr, bus_wdata}),
        .q(bus_s)
    );

    assign {pf_s, s_oe_n, s_we_n, s_reg_cs_n, s_mem_cs_n} = ctl_s;
    assign {s_addr, s_data} = bus_s;

    pbus_decode u_dec (
        .mem_cs_n(s_mem_cs_n),
        .reg_cs_n(s_reg_cs_n),
        .we_n(s_we_n),
        .mode(mode)
    );

    pbus_wrfsm #(.AW(AW), .DW(DW), .RCW(RCW)) u_wr (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .s_mem_cs_n(s_mem_cs_n), .s_reg_cs_n(s_reg_cs_n),
        .s_we_n(s_we_n), .s_pf(pf_s),
        .s_addr(s_addr), .s_data(s_data),
        .recov_cycles(recov_cycles),
        .mem_we(mem_we), .reg_we(reg_we),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign mem_addr  = mem_we ? wr_addr : s_addr;
    assign reg_addr  = reg_we ? wr_addr[REG_AW-1:0] : s_addr[REG_AW-1:0];
    assign mem_wdata = wr_data;
    assign reg_wdata = wr_data;

    assign oe_d   = ((mode == MD_MEM_RD) || (mode == MD_REG_RD)) && !s_oe_n;
    assign rd_sel = (mode == MD_REG_RD) ? reg_rdata : mem_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_mode  <= MD_STANDBY;
            bad_combo <= 1'b0;
            bus_oe    <= 1'b0;
            bus_rdata <= '0;
        end else begin
            cyc_mode  <= mode;
            bad_combo <= (mode == MD_INVALID);
            bus_oe    <= oe_d;
            bus_rdata <= oe_d ? rd_sel : '0;
        end
    end
endmodule

// File: rtl/pbus_steer_chk.sv
module pbus_steer_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic          reg_we,
    input logic          bus_oe,
    input logic [DW-1:0] bus_rdata,
    input logic [2:0]    cyc_mode,
    input logic          bad_combo,
    input logic          pf_s
);
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && reg_we));

    p_mem_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_reg_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_pf_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || reg_we) |-> !$past(pf_s));

    p_drive_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (cyc_mode == 3'd1 || cyc_mode == 3'd3));

    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_rdata == '0));

    p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_combo |-> (!bus_oe && cyc_mode == 3'd5));
endmodule

bind pbus_steer pbus_steer_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .reg_we(reg_we),
    .bus_oe(bus_oe), .bus_rdata(bus_rdata), .cyc_mode(cyc_mode),
    .bad_combo(bad_combo), .pf_s(pf_s)
);

// File: tb/tb_pbus_steer.sv
module tb_pbus_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_cs_n = 1'b1, reg_cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        pwr_fail = 1'b0;
    logic [7:0]  recov_cycles = 8'd2;
    logic [7:0]  mem_rdata, reg_rdata;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, reg_wdata, bus_rdata;
    logic        mem_we, reg_we, bus_oe, bad_combo;
    logic [3:0]  reg_addr;
    logic [2:0]  cyc_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct packed {
        logic        tgt;   // 1 = register file
        logic [19:0] a;
        logic [7:0]  d;
    } wr_item_t;
    wr_item_t exp_q[$];
    string    tag_q[$];

    always #2.5 clk = ~clk;

    // target models
    assign mem_rdata = mem_addr[7:0] ^ mem_addr[19:12];
    assign reg_rdata = {4'hA, reg_addr};

    pbus_steer dut (
        .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .reg_cs_n(reg_cs_n),
        .we_n(we_n), .oe_n(oe_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pwr_fail(pwr_fail), .recov_cycles(recov_cycles),
        .mem_rdata(mem_rdata), .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .bus_rdata(bus_rdata), .bus_oe(bus_oe), .cyc_mode(cyc_mode),
        .bad_combo(bad_combo)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(logic tgt, logic [19:0] a, logic [7:0] d, string req);
        wr_item_t it;
        it.tgt = tgt;
        it.a   = tgt ? {16'h0, a[3:0]} : a;
        it.d   = d;
        exp_q.push_back(it);
        tag_q.push_back(req);
    endtask

    task automatic mem_write(logic [19:0] a, logic [7:0] d, bit we_last,
                             bit cs_rises_first, bit ok, string req);
        bus_addr = a; bus_wdata = d; oe_n = 1'b1;
        if (we_last) begin mem_cs_n = 1'b0; settle(3); we_n = 1'b0; end
        else         begin we_n = 1'b0; settle(3); mem_cs_n = 1'b0; end
        settle(5);
        if (ok) push(1'b0, a, d, req);
        if (cs_rises_first) begin mem_cs_n = 1'b1; settle(3); we_n = 1'b1; end
        else                begin we_n = 1'b1; settle(3); mem_cs_n = 1'b1; end
        settle(8);
    endtask

    task automatic reg_write(logic [19:0] a, logic [7:0] d, bit ok, string req);
        bus_addr = a; bus_wdata = d; oe_n = 1'b1;
        reg_cs_n = 1'b0; settle(3);
        we_n = 1'b0; settle(5);
        if (ok) push(1'b1, a, d, req);
        we_n = 1'b1; settle(3);
        reg_cs_n = 1'b1; settle(8);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done && (mem_we || reg_we)) begin
            wr_item_t it;
            string    tg;
            n_cmp++;
            if (mem_we && reg_we) begin
                n_bad++;
                $display("FAIL R6: both strobes high, actual 11 expected one");
            end else if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6/R8/R9/R10: unexpected strobe mem=%0b reg=%0b addr=%0h, expected none",
                         mem_we, reg_we, mem_we ? mem_addr : {16'h0, reg_addr});
            end else begin
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (reg_we !== it.tgt ||
                    (it.tgt ? {16'h0, reg_addr} : mem_addr) !== it.a ||
                    (it.tgt ? reg_wdata : mem_wdata) !== it.d) begin
                    n_bad++;
                    $display("FAIL %s: actual tgt=%0b addr=%0h data=%0h expected tgt=%0b addr=%0h data=%0h",
                             tg, reg_we, it.tgt ? {16'h0, reg_addr} : mem_addr,
                             it.tgt ? reg_wdata : mem_wdata, it.tgt, it.a, it.d);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            while (exp_q.size() != 0) begin
                wr_item_t it;
                string    tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                n_cmp++;
                n_bad++;
                $display("FAIL %s: actual no strobe expected addr=%0h data=%0h", tg, it.a, it.d);
            end
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        settle(4);
        rst_n = 1'b1;
        settle(3);
        // R1 reset state
        chk("R1 reset mode", cyc_mode, 3'd0);
        chk("R1 reset oe", bus_oe, 1'b0);
        chk("R1 reset rdata", bus_rdata, 8'h00);
        chk("R1 reset bad", bad_combo, 1'b0);
        chk("R1 reset strobes", {mem_we, reg_we}, 2'b00);

        // R2 memory read, drive on then off
        bus_addr = 20'h12345; mem_cs_n = 1'b0; oe_n = 1'b0; settle(5);
        chk("R1 mem read mode", cyc_mode, 3'd1);
        chk("R2 mem read oe", bus_oe, 1'b1);
        chk("R2 mem read data", bus_rdata, 8'h57);
        oe_n = 1'b1; settle(5);
        chk("R2 mem read oe high", bus_oe, 1'b0);
        chk("R2 quiet data", bus_rdata, 8'h00);
        mem_cs_n = 1'b1; settle(5);

        // R2 register read
        bus_addr = 20'h00007; reg_cs_n = 1'b0; oe_n = 1'b0; settle(5);
        chk("R1 reg read mode", cyc_mode, 3'd3);
        chk("R2 reg read oe", bus_oe, 1'b1);
        chk("R2 reg read data", bus_rdata, 8'hA7);
        oe_n = 1'b1; settle(5);
        chk("R1 reg read mode oe high", cyc_mode, 3'd3);
        chk("R2 reg read no drive", bus_oe, 1'b0);
        reg_cs_n = 1'b1; settle(5);

        // R5 standby with we and oe low
        we_n = 1'b0; oe_n = 1'b0; settle(5);
        chk("R5 standby mode", cyc_mode, 3'd0);
        chk("R5 standby no drive", bus_oe, 1'b0);
        we_n = 1'b1; oe_n = 1'b1; settle(8);

        // R3 write enable falling turns drive off
        bus_addr = 20'h0ABCD; bus_wdata = 8'h91; mem_cs_n = 1'b0; oe_n = 1'b0; settle(5);
        chk("R3 drive before write", bus_oe, 1'b1);
        we_n = 1'b0; settle(5);
        chk("R3 drive off on write", bus_oe, 1'b0);
        chk("R1 mem write mode", cyc_mode, 3'd2);
        push(1'b0, 20'h0ABCD, 8'h91, "R3");
        we_n = 1'b1; settle(3);
        mem_cs_n = 1'b1; oe_n = 1'b1; settle(8);

        // R6 memory writes, both framing orders
        mem_write(20'h00010, 8'h3C, 1'b1, 1'b0, 1'b1, "R6 we last, we first up");
        mem_write(20'hFFFFF, 8'hA5, 1'b0, 1'b1, 1'b1, "R6 cs last, cs first up");

        // R7 register writes
        reg_write(20'h0000B, 8'h5E, 1'b1, "R7 reg write B");
        reg_write(20'h12343, 8'hC7, 1'b1, "R7 reg write 3");
        chk("R1 reg write returns standby", cyc_mode, 3'd0);

        // R4 invalid combination
        bus_addr = 20'h00020; mem_cs_n = 1'b0; settle(3);
        reg_cs_n = 1'b0; oe_n = 1'b0; settle(5);
        chk("R4 invalid mode", cyc_mode, 3'd5);
        chk("R4 invalid flag", bad_combo, 1'b1);
        chk("R4 invalid no drive", bus_oe, 1'b0);
        we_n = 1'b0; settle(5);
        chk("R4 invalid flag with we", bad_combo, 1'b1);
        we_n = 1'b1; settle(3);
        reg_cs_n = 1'b1; settle(3);
        mem_cs_n = 1'b1; oe_n = 1'b1; settle(8);
        chk("R4 flag clears", bad_combo, 1'b0);

        // R8 power-fail pulse inside a memory window
        bus_addr = 20'h00300; bus_wdata = 8'h11; mem_cs_n = 1'b0; settle(3);
        we_n = 1'b0; settle(4);
        pwr_fail = 1'b1; settle(3);
        pwr_fail = 1'b0; settle(4);
        we_n = 1'b1; settle(3);
        mem_cs_n = 1'b1; settle(8);
        // R8 power fail held across a register write
        pwr_fail = 1'b1;
        reg_write(20'h00005, 8'h22, 1'b0, "R8");
        pwr_fail = 1'b0; settle(4);
        reg_write(20'h00005, 8'h33, 1'b1, "R8 write after recovery of supply");

        // R9 address change inside a window
        bus_addr = 20'h00400; bus_wdata = 8'h44; mem_cs_n = 1'b0; settle(3);
        we_n = 1'b0; settle(4);
        bus_addr = 20'h00401; settle(4);
        we_n = 1'b1; settle(3);
        mem_cs_n = 1'b1; settle(8);
        mem_write(20'h00402, 8'h55, 1'b1, 1'b0, 1'b1, "R9 write after abort");

        // R10 recovery window
        recov_cycles = 8'd20; settle(2);
        mem_write(20'h00500, 8'h66, 1'b1, 1'b0, 1'b1, "R10 first write");
        mem_write(20'h00501, 8'h77, 1'b1, 1'b0, 1'b0, "R10");
        settle(40);
        mem_write(20'h00502, 8'h88, 1'b1, 1'b0, 1'b1, "R10 write after recovery");

        settle(10);
        finish_run();
    end
endmodule